// File: doc/BRIEF.md
# Power-On Reset Bypass Detector

This block produces the internal core reset after power comes up. The reset normally stays asserted until a start-up interval has elapsed, which gives a slow crystal oscillator time to settle. For fast board test, the block also watches the two serial-bus lines, SDA and SCL. A timed toggle pattern on those lines ends the start-up reset at once and raises an override-active flag.

A register-side test-enable bit decides whether the pattern is accepted. Writing 0 to it drops an active override. While it holds 0, the bus lines are ignored, so it must be written back to 1 before the override can be entered again. Clearing it has no other effect, and in particular it never puts the core back into reset.

All intervals are counted on a free-running reference clock. The thresholds are given in nanoseconds and converted to clock cycles at elaboration time from a clock-rate parameter in MHz. Power-good going low returns the block asynchronously to its initial state.

The recogniser is a five-state machine:
- IDLE waits for SDA high with SCL low.
- READY waits for SDA to fall while SCL stays low.
- SDA_LOW times the SDA-low phase.
- SCL_HIGH times the SCL-high phase.
- OVERRIDE holds the recognised condition.

Its transitions are:
- arm (IDLE to READY).
- sda_fall (READY to SDA_LOW).
- scl_rise_ok (SDA_LOW to SCL_HIGH).
- scl_hold_ok (SCL_HIGH to OVERRIDE).
- abort: any phase to IDLE on a short phase, a wrong edge, or a closed window.
- clear: any state to IDLE when the test-enable bit is written 0 or reads 0.

Top module: `por_bypass_detector`

## Requirements
- R1: While `pwr_ok` is low, `core_rst` is 1 and `bypass_active` is 0, independent of the clock.
- R2: With no valid pattern, `core_rst` falls once the start-up interval (STARTUP_NS) has been counted after `pwr_ok` rises, and `bypass_active` stays 0.
- R3: A valid pattern releases `core_rst` at once, before the start-up interval ends, and sets `bypass_active` to 1. The pattern is: with SCL low, SDA falls and stays low for at least SDA_LOW_NS; SCL then rises and stays high for at least SCL_HIGH_NS.
- R4: If SCL rises before SDA has been low for SDA_LOW_NS, recognition aborts. No override follows and `core_rst` stays 1.
- R5: If SCL falls before it has been high for SCL_HIGH_NS, recognition aborts. No override follows.
- R6: Phases longer than their minimum are accepted, so an override results.
- R7: An SCL rise after the window (WINDOW_NS after power-up) is not accepted. `core_rst` then follows the start-up interval.
- R8: Writing 0 to the test-enable bit (`te_we`=1, `te_wdata`=0) drops `bypass_active` on the next cycle. It leaves `core_rst` at 0.
- R9: While the test-enable bit is 0, a valid pattern is ignored. Writing it back to 1 allows a new override.
- R10: The test-enable bit is 1 after power-up, so a pattern is accepted without any prior write.
- R11: SDA rising during either timed phase aborts recognition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| pwr_ok | input | 1 | Asynchronous power-good, low = reset |
| sda_in | input | 1 | Serial data line level |
| scl_in | input | 1 | Serial clock line level |
| te_we | input | 1 | Write strobe for the test-enable bit |
| te_wdata | input | 1 | Value written to the test-enable bit |
| core_rst | output | 1 | Internal reset, active high |
| bypass_active | output | 1 | Override recognised and still in force |

## Verification
A phase counter that is off, or a state that is skipped, shows up at the ports as an override that appears or goes missing at the end of a pattern. It becomes visible a few cycles after the falling edge of SCL. A wrong start-up count shows as a `core_rst` edge outside a narrow band around the expected cycle. A lost sticky release shows as `core_rst` rising again after a clear. The random patterns keep their phase lengths away from the thresholds, so that an error of a single cycle cannot mask a logic fault.

// File: rtl/porb_pkg.sv
package porb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READY,
        ST_SDA_LOW,
        ST_SCL_HIGH,
        ST_OVERRIDE
    } det_state_t;

    // Rounds up so that a minimum interval is never shortened.
    function automatic longint unsigned ns_to_cycles(longint unsigned ns,
                                                     longint unsigned mhz);
        return (ns * mhz + 64'd999) / 64'd1000;
    endfunction

endpackage

// File: rtl/porb_sync2.sv
module porb_sync2 #(
    parameter int unsigned W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end

endmodule

// File: rtl/porb_startup_timer.sv
module porb_startup_timer #(
    parameter int unsigned STARTUP_CYC = 1000,
    parameter int unsigned WINDOW_CYC  = 500
) (
    input  logic clk,
    input  logic rst_n,
    output logic window_open,
    output logic expired
);

    localparam int unsigned CW = $clog2(STARTUP_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STARTUP_CYC);
    localparam logic [CW-1:0] WLIM  = CW'(WINDOW_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        expired     = (cnt == LIMIT);
        window_open = (cnt < WLIM);
    end

endmodule

// File: rtl/porb_testen_reg.sv
module porb_testen_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wdata,
    output logic te_q,
    output logic clr_pulse
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            te_q <= 1'b1;
        end else if (we) begin
            te_q <= wdata;
        end
    end

    always_comb clr_pulse = we & ~wdata;

endmodule

// File: rtl/porb_pattern_fsm.sv
module porb_pattern_fsm
    import porb_pkg::*;
#(
    parameter int unsigned SDA_CYC = 125,
    parameter int unsigned SCL_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda,
    input  logic scl,
    input  logic arm,
    input  logic clr,
    input  logic window_open,
    output logic recog
);

    localparam int unsigned MAXC = (SDA_CYC > SCL_CYC) ? SDA_CYC : SCL_CYC;
    localparam int unsigned CNTW = $clog2(MAXC + 1);
    localparam logic [CNTW-1:0] SDA_LIM = CNTW'(SDA_CYC);
    localparam logic [CNTW-1:0] SCL_LIM = CNTW'(SCL_CYC);
    localparam logic [CNTW-1:0] SAT     = CNTW'(MAXC);

    det_state_t      state, state_nx;
    logic [CNTW-1:0] phase_cnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Phase timer: restarts at 1 on every state change, saturates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_cnt <= '0;
        end else if (state_nx != state) begin
            phase_cnt <= CNTW'(1);
        end else if (phase_cnt != SAT) begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        if (clr || !arm) begin
            state_nx = ST_IDLE;                        // clear
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (sda && !scl) state_nx = ST_READY;          // arm
                end
                ST_READY: begin
                    if (scl)       state_nx = ST_IDLE;             // abort
                    else if (!sda) state_nx = ST_SDA_LOW;          // sda_fall
                end
                ST_SDA_LOW: begin
                    if (sda) begin
                        state_nx = ST_IDLE;                        // abort
                    end else if (scl) begin
                        if (window_open && phase_cnt >= SDA_LIM)
                            state_nx = ST_SCL_HIGH;                // scl_rise_ok
                        else
                            state_nx = ST_IDLE;                    // abort
                    end
                end
                ST_SCL_HIGH: begin
                    if (sda || !scl)             state_nx = ST_IDLE;     // abort
                    else if (phase_cnt >= SCL_LIM) state_nx = ST_OVERRIDE; // scl_hold_ok
                end
                ST_OVERRIDE: state_nx = ST_OVERRIDE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb recog = (state == ST_OVERRIDE);

endmodule

// File: rtl/por_bypass_detector.sv
module por_bypass_detector
    import porb_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 100,
    parameter int unsigned STARTUP_NS  = 20_000_000,
    parameter int unsigned WINDOW_NS   = 8_000_000,
    parameter int unsigned SDA_LOW_NS  = 500,
    parameter int unsigned SCL_HIGH_NS = 2000
) (
    input  logic clk_ref,
    input  logic pwr_ok,
    input  logic sda_in,
    input  logic scl_in,
    input  logic te_we,
    input  logic te_wdata,
    output logic core_rst,
    output logic bypass_active
);

    localparam int unsigned STARTUP_CYC = int'(ns_to_cycles(STARTUP_NS, CLK_MHZ));
    localparam int unsigned WINDOW_CYC  = int'(ns_to_cycles(WINDOW_NS, CLK_MHZ));
    localparam int unsigned SDA_CYC     = int'(ns_to_cycles(SDA_LOW_NS, CLK_MHZ));
    localparam int unsigned SCL_CYC     = int'(ns_to_cycles(SCL_HIGH_NS, CLK_MHZ));

    logic [1:0] bus_s;
    logic       window_open, startup_done;
    logic       te_q, te_clr;
    logic       recog;
    logic       rel_q;

    porb_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk_ref),
        .rst_n (pwr_ok),
        .d     ({scl_in, sda_in}),
        .q     (bus_s)
    );

    porb_startup_timer #(.STARTUP_CYC(STARTUP_CYC), .WINDOW_CYC(WINDOW_CYC)) u_timer (
        .clk         (clk_ref),
        .rst_n       (pwr_ok),
        .window_open (window_open),
        .expired     (startup_done)
    );

    porb_testen_reg u_te (
        .clk       (clk_ref),
        .rst_n     (pwr_ok),
        .we        (te_we),
        .wdata     (te_wdata),
        .te_q      (te_q),
        .clr_pulse (te_clr)
    );

    porb_pattern_fsm #(.SDA_CYC(SDA_CYC), .SCL_CYC(SCL_CYC)) u_fsm (
        .clk         (clk_ref),
        .rst_n       (pwr_ok),
        .sda         (bus_s[0]),
        .scl         (bus_s[1]),
        .arm         (te_q),
        .clr         (te_clr),
        .window_open (window_open),
        .recog       (recog)
    );

    // Sticky release: once out of reset, only power-good brings it back
    always_ff @(posedge clk_ref or negedge pwr_ok) begin
        if (!pwr_ok) begin
            rel_q <= 1'b0;
        end else if (startup_done || recog) begin
            rel_q <= 1'b1;
        end
    end

    always_comb begin
        core_rst      = ~(rel_q | startup_done | recog);
        bypass_active = recog;
    end

endmodule

// File: rtl/porb_chk.sv
module porb_chk (
    input logic clk,
    input logic pwr_ok,
    input logic core_rst,
    input logic bypass_active,
    input logic te_we,
    input logic te_wdata,
    input logic te_q,
    input logic expired
);

    always @(posedge clk) begin
        if (!pwr_ok) begin
            assert_rst_in_power_loss_R1: assert (core_rst && !bypass_active)
                else $error("core_rst/bypass wrong while power low");
        end
    end

    assert_timer_releases_R2: assert property (@(posedge clk) disable iff (!pwr_ok)
        expired |-> !core_rst);

    assert_override_releases_R3: assert property (@(posedge clk) disable iff (!pwr_ok)
        bypass_active |-> !core_rst);

    assert_no_reassert_R8: assert property (@(posedge clk) disable iff (!pwr_ok)
        !core_rst |=> !core_rst);

    assert_clear_drops_flag_R8: assert property (@(posedge clk) disable iff (!pwr_ok)
        (te_we && !te_wdata) |=> !bypass_active);

    assert_entry_needs_enable_R9: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(bypass_active) |-> te_q);

endmodule

bind por_bypass_detector porb_chk u_chk (
    .clk           (clk_ref),
    .pwr_ok        (pwr_ok),
    .core_rst      (core_rst),
    .bypass_active (bypass_active),
    .te_we         (te_we),
    .te_wdata      (te_wdata),
    .te_q          (te_q),
    .expired       (startup_done)
);

// File: tb/sim_por_bypass_detector.sv
module sim_por_bypass_detector;

    localparam int CLK_MHZ  = 250;
    localparam int STARTUP  = 20000;   // cycles (80 us)
    localparam int WINDOW   = 10000;   // cycles (40 us)
    localparam int SDA_MIN  = 125;     // 500 ns
    localparam int SCL_MIN  = 500;     // 2000 ns

    logic clk_ref = 1'b0;
    logic pwr_ok = 1'b0;
    logic sda_in = 1'b1;
    logic scl_in = 1'b0;
    logic te_we = 1'b0;
    logic te_wdata = 1'b1;
    logic core_rst, bypass_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk_ref = ~clk_ref;

    por_bypass_detector #(
        .CLK_MHZ(CLK_MHZ), .STARTUP_NS(80_000), .WINDOW_NS(40_000),
        .SDA_LOW_NS(500), .SCL_HIGH_NS(2000)
    ) u0 (
        .clk_ref(clk_ref), .pwr_ok(pwr_ok), .sda_in(sda_in), .scl_in(scl_in),
        .te_we(te_we), .te_wdata(te_wdata),
        .core_rst(core_rst), .bypass_active(bypass_active)
    );

    function automatic bit exp_override(int lo, int hi, bit te);
        return te && (lo >= SDA_MIN) && (hi >= SCL_MIN);
    endfunction

    task automatic chk(string req, logic act, logic expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic power_cycle();
        @(negedge clk_ref);
        pwr_ok = 1'b0; sda_in = 1'b1; scl_in = 1'b0; te_we = 1'b0;
        cyc(3);
        pwr_ok = 1'b1;
        cyc(4);
    endtask

    task automatic write_te(bit v);
        te_we = 1'b1; te_wdata = v;
        cyc(1);
        te_we = 1'b0;
    endtask

    task automatic pattern(int lo, int hi);
        sda_in = 1'b0;
        cyc(lo);
        scl_in = 1'b1;
        cyc(hi);
        scl_in = 1'b0;
        cyc(3);
        sda_in = 1'b1;
        cyc(20);
    endtask

    initial begin
        // R1: reset state while power is low
        cyc(2);
        chk("R1 core_rst", core_rst, 1'b1);
        chk("R1 bypass", bypass_active, 1'b0);

        // R2: start-up timer alone
        power_cycle();
        cyc(STARTUP - 20);
        chk("R2 before expiry", core_rst, 1'b1);
        cyc(30);
        chk("R2 after expiry", core_rst, 1'b0);
        chk("R2 no flag", bypass_active, 1'b0);
        // R1 again: drop power asynchronously mid-cycle
        #1 pwr_ok = 1'b0;
        #0.5;
        chk("R1 async core_rst", core_rst, 1'b1);

        // R3, R10: valid pattern without any write
        power_cycle();
        sda_in = 1'b0;
        cyc(200);
        scl_in = 1'b1;
        cyc(SCL_MIN - 20);
        chk("R3 still in reset", core_rst, 1'b1);
        cyc(40);
        chk("R3 released", core_rst, 1'b0);
        chk("R10 flag set", bypass_active, 1'b1);
        scl_in = 1'b0;
        cyc(5);
        sda_in = 1'b1;
        cyc(5);
        // R8: clear
        write_te(1'b0);
        chk("R8 flag cleared", bypass_active, 1'b0);
        cyc(5);
        chk("R8 no reassert", core_rst, 1'b0);
        // R9: ignored while disabled, re-armed by writing 1
        pattern(200, 700);
        chk("R9 ignored", bypass_active, 1'b0);
        write_te(1'b1);
        cyc(3);
        pattern(200, 700);
        chk("R9 re-entry", bypass_active, 1'b1);

        // R4: SDA-low phase too short
        power_cycle();
        pattern(60, 700);
        chk("R4 no flag", bypass_active, 1'b0);
        chk("R4 reset held", core_rst, 1'b1);

        // R5: SCL-high phase too short
        power_cycle();
        pattern(200, 300);
        chk("R5 no flag", bypass_active, 1'b0);
        chk("R5 reset held", core_rst, 1'b1);

        // R11: SDA rising inside SCL-high phase
        power_cycle();
        sda_in = 1'b0;
        cyc(200);
        scl_in = 1'b1;
        cyc(200);
        sda_in = 1'b1;
        cyc(500);
        scl_in = 1'b0;
        cyc(20);
        chk("R11 no flag", bypass_active, 1'b0);
        chk("R11 reset held", core_rst, 1'b1);

        // R7: SCL rise after the window
        power_cycle();
        sda_in = 1'b0;
        cyc(WINDOW + 100);
        scl_in = 1'b1;
        cyc(700);
        scl_in = 1'b0;
        sda_in = 1'b1;
        cyc(20);
        chk("R7 no flag", bypass_active, 1'b0);
        chk("R7 reset held", core_rst, 1'b1);
        cyc(STARTUP - (WINDOW + 100 + 720 + 4) + 30);
        chk("R7 timer release", core_rst, 1'b0);

        // R6 plus random mix, phase lengths kept off the thresholds
        for (int t = 0; t < 14; t++) begin
            int lo, hi;
            bit e;
            lo = (($urandom % 2) != 0) ? 40 + int'($urandom % 75) : 140 + int'($urandom % 200);
            hi = (($urandom % 2) != 0) ? 150 + int'($urandom % 330) : 520 + int'($urandom % 400);
            e = exp_override(lo, hi, 1'b1);
            power_cycle();
            pattern(lo, hi);
            chk("R6 random flag", bypass_active, e);
            chk("R6 random reset", core_rst, ~e);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (195000) @(posedge clk_ref);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule